// File: doc/BRIEF.md
# Expander Stop Request Handler

This block is the error concentrator and stop agent of one interconnect expander that hosts two board slots. In the upward direction it gathers the error lines of each slot (a separate line for ECC errors and one for every other error class) together with error requests from the expander's own agents. It raises a single held stop request toward the central arbiters and keeps it up until they acknowledge it. Beside the request it reports which error classes were seen.

In the downward direction the arbiters broadcast a stop message that names the stop kind, the domain in error and the failing expander and slot. The block compares the message with its programmable domain membership and halts only what belongs to the failing domain. For each slot that must stop it raises a pause line to that slot's board agent. For each local half (data agents and address queue half) that must stop it raises a stop enable, and it also flags its own halt. When the expander is split between two domains, each slot and its half are judged on their own, so a fault in one domain never stops the other. A stop stays in force until software clears it through the register write port.

Top module: `exp_stop_agent`

## Requirements
- R1: When any slot error, slot ECC error or local error line is high at a clock edge, `stop_req` is high from the next cycle and stays high until the cycle after a `stop_ack` edge at which no error line is high; an error at the same edge as the acknowledge keeps the request high.
- R2: `req_cause` bit 0 records any non-ECC slot error or local error and bit 1 records any slot ECC error seen while the request is pending; both clear with the request, and at an acknowledge edge with a new error only the new classes remain.
- R3: Register writes: address s (s below the slot count) holds slot s's domain ID in the low bits and its enable in the top data bit; address equal to the slot count holds the own expander ID in the low bits and the split enable in the top data bit; the next address is the clear-stop command. All fields reset to zero.
- R4: Domain stop message (kind 0) with split disabled: if its domain ID equals slot 0's domain register, every local half is stopped and every enabled slot is paused.
- R5: Domain stop message with split enabled: each slot and its half stop only if the message domain equals that slot's own domain register.
- R6: A slot whose enable bit is 0 is never paused, although its half may still be stopped.
- R7: Port stop message (kind 1) acts only when its expander ID equals the own expander ID; with split enabled only the named slot and its half stop, with split disabled the whole expander stops.
- R8: A message that selects no half leaves all outputs low and the block ready for the next message.
- R9: Once a stop is taken, pause and half-stop outputs hold their values and further messages are ignored until a clear-stop write.
- R10: A clear-stop write drops all pause, half-stop and halt outputs at the next cycle; a message arriving at the same edge as the clear is discarded.
- R11: `self_halt` is high exactly while at least one half is stopped, and a paused slot always has its half stopped.
- R12: Stop outputs change one cycle after the message edge; all outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_err | input | NUM_SLOTS | Non-ECC error line per slot |
| slot_ecc_err | input | NUM_SLOTS | ECC error line per slot |
| local_err | input | NUM_LOCAL | Error requests from expander agents |
| stop_ack | input | 1 | Arbiter acknowledge of the stop request |
| stop_req | output | 1 | Held stop request to the arbiters |
| req_cause | output | 2 | Error classes seen: bit 0 other, bit 1 ECC |
| msg_valid | input | 1 | Stop message strobe |
| msg_kind | input | 1 | 0 domain stop, 1 port stop |
| msg_dom | input | DOM_W | Domain ID in error |
| msg_exp | input | EXP_W | Expander ID in error |
| msg_slot | input | SLOT_W | Slot index in error |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | CFG_DW | Register write data |
| slot_pause | output | NUM_SLOTS | Pause line per slot board agent |
| half_stop | output | NUM_SLOTS | Stop enable per local half |
| self_halt | output | 1 | Expander agent halted |

## Verification
The bench builds the block with its defaults: two slots, three local error sources and five-bit domain and expander IDs, so a write's data is six bits with the enable on top. Two slots are the least that separate shared from split operation, letting one domain's message be shown to leave the other slot running, and three local sources show that every agent line reaches the request. Five-bit IDs allow distinct domains and a foreign expander ID to prove that port stops aimed elsewhere are ignored.

// File: rtl/exp_stop_pkg.sv
// Shared types for the expander stop handler.
package exp_stop_pkg;
    // Stop message kinds as carried on msg_kind
    typedef enum logic {
        KIND_DOMAIN = 1'b0,
        KIND_PORT   = 1'b1
    } stop_kind_e;
endpackage

// File: rtl/exp_stop_err_gather.sv
// Upward path: merges slot and local error lines into one held stop request
// plus a two-bit record of error classes. Assumes error lines are synchronous.
module exp_stop_err_gather #(
    parameter int NUM_SLOTS = 2,
    parameter int NUM_LOCAL = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_err,
    input  logic [NUM_SLOTS-1:0] slot_ecc_err,
    input  logic [NUM_LOCAL-1:0] local_err,
    input  logic                 stop_ack,
    output logic                 stop_req,
    output logic [1:0]           req_cause
);
    logic other_seen;
    logic ecc_seen;

    // Collapse the error lines into two class flags
    always_comb begin
        other_seen = (|slot_err) | (|local_err);
        ecc_seen   = |slot_ecc_err;
    end

    // Hold the request from first error until acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_req  <= 1'b0;
            req_cause <= 2'b00;
        end else if (other_seen || ecc_seen) begin
            stop_req  <= 1'b1;
            req_cause <= (stop_ack ? 2'b00 : req_cause) | {ecc_seen, other_seen};
        end else if (stop_ack) begin
            stop_req  <= 1'b0;
            req_cause <= 2'b00;
        end
    end
endmodule

// File: rtl/exp_stop_cfg.sv
// Configuration registers: per-slot domain ID and enable, own expander ID,
// split enable, and a clear-stop command decoded as a one-cycle pulse.
module exp_stop_cfg #(
    parameter int NUM_SLOTS = 2,
    parameter int DOM_W     = 5,
    parameter int EXP_W     = 5,
    parameter int ADDR_W    = 2,
    parameter int CFG_DW    = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic [CFG_DW-1:0]               cfg_wdata,
    output logic [NUM_SLOTS-1:0][DOM_W-1:0] slot_dom,
    output logic [NUM_SLOTS-1:0]            slot_en,
    output logic [EXP_W-1:0]                own_exp,
    output logic                            split_en,
    output logic                            clr_pulse
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_SLOTS);
    localparam logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'(NUM_SLOTS + 1);
    localparam int                EN_BIT    = CFG_DW - 1;

    genvar s;
    generate
        for (s = 0; s < NUM_SLOTS; s++) begin : g_slot_reg
            // Per-slot domain membership register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_dom[s] <= '0;
                    slot_en[s]  <= 1'b0;
                end else if (cfg_we && cfg_addr == ADDR_W'(s)) begin
                    slot_dom[s] <= cfg_wdata[DOM_W-1:0];
                    slot_en[s]  <= cfg_wdata[EN_BIT];
                end
            end
        end
    endgenerate

    // Expander control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_exp  <= '0;
            split_en <= 1'b0;
        end else if (cfg_we && cfg_addr == CTRL_ADDR) begin
            own_exp  <= cfg_wdata[EXP_W-1:0];
            split_en <= cfg_wdata[EN_BIT];
        end
    end

    // Clear-stop command decode
    always_comb clr_pulse = cfg_we && (cfg_addr == CLR_ADDR);
endmodule

// File: rtl/exp_stop_match.sv
// Combinational decision of which slots pause and which halves stop for an
// incoming message, honouring domain membership and split mode.
module exp_stop_match
    import exp_stop_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int DOM_W     = 5,
    parameter int EXP_W     = 5,
    parameter int SLOT_W    = 1
) (
    input  stop_kind_e                      kind,
    input  logic [DOM_W-1:0]                msg_dom,
    input  logic [EXP_W-1:0]                msg_exp,
    input  logic [SLOT_W-1:0]               msg_slot,
    input  logic [NUM_SLOTS-1:0][DOM_W-1:0] slot_dom,
    input  logic [NUM_SLOTS-1:0]            slot_en,
    input  logic [EXP_W-1:0]                own_exp,
    input  logic                            split_en,
    output logic [NUM_SLOTS-1:0]            pause_hit,
    output logic [NUM_SLOTS-1:0]            half_hit
);
    logic exp_hit;
    logic shared_hit;

    // Whole-expander match used when the expander is not split
    always_comb begin
        exp_hit    = (msg_exp == own_exp);
        shared_hit = (kind == KIND_DOMAIN) ? (msg_dom == slot_dom[0]) : exp_hit;
    end

    genvar s;
    generate
        for (s = 0; s < NUM_SLOTS; s++) begin : g_slot_match
            logic own_hit;
            // Per-slot match and resulting half/pause decision
            always_comb begin
                own_hit = (kind == KIND_DOMAIN) ? (msg_dom == slot_dom[s])
                                                : (exp_hit && msg_slot == SLOT_W'(s));
                half_hit[s]  = split_en ? own_hit : shared_hit;
                pause_hit[s] = half_hit[s] && slot_en[s];
            end
        end
    endgenerate
endmodule

// File: rtl/exp_stop_hold.sv
// Stop state: captures the first effective message and holds the pause and
// half-stop pattern until a clear-stop command.
module exp_stop_hold #(
    parameter int NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_valid,
    input  logic                 clr_pulse,
    input  logic [NUM_SLOTS-1:0] pause_hit,
    input  logic [NUM_SLOTS-1:0] half_hit,
    output logic [NUM_SLOTS-1:0] slot_pause,
    output logic [NUM_SLOTS-1:0] half_stop,
    output logic                 self_halt
);
    // Capture, hold and clear the stop pattern
    always_ff @(posedge clk) begin
        if (!rst_n || clr_pulse) begin
            slot_pause <= '0;
            half_stop  <= '0;
            self_halt  <= 1'b0;
        end else if (msg_valid && !self_halt && (|half_hit)) begin
            slot_pause <= pause_hit;
            half_stop  <= half_hit;
            self_halt  <= 1'b1;
        end
    end
endmodule

// File: rtl/exp_stop_agent.sv
// Top of the expander stop handler: upward error concentration, register
// port, message matching and stop state. Assumes a single clock domain.
module exp_stop_agent
    import exp_stop_pkg::*;
#(
    parameter int  NUM_SLOTS = 2,
    parameter int  NUM_LOCAL = 3,
    parameter int  DOM_W     = 5,
    parameter int  EXP_W     = 5,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int ADDR_W    = $clog2(NUM_SLOTS + 2),
    localparam int CFG_DW    = ((DOM_W > EXP_W) ? DOM_W : EXP_W) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_err,
    input  logic [NUM_SLOTS-1:0] slot_ecc_err,
    input  logic [NUM_LOCAL-1:0] local_err,
    input  logic                 stop_ack,
    output logic                 stop_req,
    output logic [1:0]           req_cause,
    input  logic                 msg_valid,
    input  logic                 msg_kind,
    input  logic [DOM_W-1:0]     msg_dom,
    input  logic [EXP_W-1:0]     msg_exp,
    input  logic [SLOT_W-1:0]    msg_slot,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    output logic [NUM_SLOTS-1:0] slot_pause,
    output logic [NUM_SLOTS-1:0] half_stop,
    output logic                 self_halt
);
    logic [NUM_SLOTS-1:0][DOM_W-1:0] slot_dom;
    logic [NUM_SLOTS-1:0]            slot_en;
    logic [EXP_W-1:0]                own_exp;
    logic                            split_en;
    logic                            clr_pulse;
    logic [NUM_SLOTS-1:0]            pause_hit;
    logic [NUM_SLOTS-1:0]            half_hit;
    stop_kind_e                      kind;

    // Map the raw kind bit onto the package type
    always_comb kind = stop_kind_e'(msg_kind);

    exp_stop_err_gather #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_LOCAL(NUM_LOCAL)
    ) u_gather (
        .clk(clk), .rst_n(rst_n), .slot_err(slot_err), .slot_ecc_err(slot_ecc_err),
        .local_err(local_err), .stop_ack(stop_ack), .stop_req(stop_req),
        .req_cause(req_cause)
    );

    exp_stop_cfg #(
        .NUM_SLOTS(NUM_SLOTS), .DOM_W(DOM_W), .EXP_W(EXP_W),
        .ADDR_W(ADDR_W), .CFG_DW(CFG_DW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .slot_dom(slot_dom), .slot_en(slot_en),
        .own_exp(own_exp), .split_en(split_en), .clr_pulse(clr_pulse)
    );

    exp_stop_match #(
        .NUM_SLOTS(NUM_SLOTS), .DOM_W(DOM_W), .EXP_W(EXP_W), .SLOT_W(SLOT_W)
    ) u_match (
        .kind(kind), .msg_dom(msg_dom), .msg_exp(msg_exp), .msg_slot(msg_slot),
        .slot_dom(slot_dom), .slot_en(slot_en), .own_exp(own_exp),
        .split_en(split_en), .pause_hit(pause_hit), .half_hit(half_hit)
    );

    exp_stop_hold #(
        .NUM_SLOTS(NUM_SLOTS)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .clr_pulse(clr_pulse),
        .pause_hit(pause_hit), .half_hit(half_hit), .slot_pause(slot_pause),
        .half_stop(half_stop), .self_halt(self_halt)
    );
endmodule

// File: rtl/exp_stop_agent_chk.sv
// Property checker for the expander stop handler, bound to the top module.
module exp_stop_agent_chk #(
    parameter int NUM_SLOTS = 2,
    parameter int NUM_LOCAL = 3,
    parameter int ADDR_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SLOTS-1:0] slot_err,
    input logic [NUM_SLOTS-1:0] slot_ecc_err,
    input logic [NUM_LOCAL-1:0] local_err,
    input logic                 stop_ack,
    input logic                 stop_req,
    input logic                 cfg_we,
    input logic [ADDR_W-1:0]    cfg_addr,
    input logic                 split_en,
    input logic [NUM_SLOTS-1:0] slot_pause,
    input logic [NUM_SLOTS-1:0] half_stop,
    input logic                 self_halt
);
    logic clr_wr;
    logic any_err;

    // Observe clear writes and error activity at the ports
    always_comb begin
        clr_wr  = cfg_we && (cfg_addr == ADDR_W'(NUM_SLOTS + 1));
        any_err = (|slot_err) | (|slot_ecc_err) | (|local_err);
    end

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req && !stop_ack |=> stop_req);

    // R1
    req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> $past(any_err));

    // R9
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        self_halt && !clr_wr |=> $stable(slot_pause) && $stable(half_stop));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (slot_pause == '0) && (half_stop == '0) && !self_halt);

    // R11
    pause_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pause & ~half_stop) == '0);

    // R11
    halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        self_halt == (half_stop != '0));

    // R4
    shared_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_halt) && $past(!split_en) |-> (&half_stop));
endmodule

bind exp_stop_agent exp_stop_agent_chk #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_LOCAL(NUM_LOCAL), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .slot_err(slot_err), .slot_ecc_err(slot_ecc_err),
    .local_err(local_err), .stop_ack(stop_ack), .stop_req(stop_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .split_en(split_en),
    .slot_pause(slot_pause), .half_stop(half_stop), .self_halt(self_halt)
);

// File: tb/exp_stop_agent_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the expander stop handler; one task per scenario.
module exp_stop_agent_tb_top;
    localparam int NS = 2;
    localparam int NL = 3;
    localparam int DW = 5;
    localparam int EW = 5;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_CLR  = 2'd3;
    localparam logic [5:0] EN     = 6'h20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] slot_err = '0;
    logic [NS-1:0] slot_ecc_err = '0;
    logic [NL-1:0] local_err = '0;
    logic          stop_ack = 1'b0;
    logic          stop_req;
    logic [1:0]    req_cause;
    logic          msg_valid = 1'b0;
    logic          msg_kind = 1'b0;
    logic [DW-1:0] msg_dom = '0;
    logic [EW-1:0] msg_exp = '0;
    logic [0:0]    msg_slot = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [5:0]    cfg_wdata = '0;
    logic [NS-1:0] slot_pause;
    logic [NS-1:0] half_stop;
    logic          self_halt;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    exp_stop_agent dut_i (
        .clk(clk), .rst_n(rst_n), .slot_err(slot_err), .slot_ecc_err(slot_ecc_err),
        .local_err(local_err), .stop_ack(stop_ack), .stop_req(stop_req),
        .req_cause(req_cause), .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_dom(msg_dom), .msg_exp(msg_exp), .msg_slot(msg_slot),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .slot_pause(slot_pause), .half_stop(half_stop), .self_halt(self_halt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic stop_out(input string req, input int p, input int h, input int halt);
        chk(req, "slot_pause", int'(slot_pause), p);
        chk(req, "half_stop", int'(half_stop), h);
        chk(req, "self_halt", int'(self_halt), halt);
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic msg(input logic k, input int d, input int e, input int s);
        msg_valid = 1'b1; msg_kind = k;
        msg_dom = DW'(d); msg_exp = EW'(e); msg_slot = 1'(s);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic ack();
        stop_ack = 1'b1;
        @(negedge clk);
        stop_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12", "reset stop_req", int'(stop_req), 0);
        chk("R12", "reset cause", int'(req_cause), 0);
        stop_out("R12", 0, 0, 0);
    endtask

    task automatic t_upward();
        slot_err = 2'b10; @(negedge clk); slot_err = '0;
        chk("R1", "req after slot error", int'(stop_req), 1);
        chk("R2", "cause other", int'(req_cause), 1);
        repeat (3) @(negedge clk);
        chk("R1", "req held without ack", int'(stop_req), 1);
        slot_ecc_err = 2'b01; @(negedge clk); slot_ecc_err = '0;
        chk("R2", "cause accumulates", int'(req_cause), 3);
        ack();
        chk("R1", "req drops on ack", int'(stop_req), 0);
        chk("R2", "cause cleared", int'(req_cause), 0);
        local_err = 3'b100; @(negedge clk); local_err = '0;
        chk("R1", "req after local error", int'(stop_req), 1);
        chk("R2", "local counts as other", int'(req_cause), 1);
        stop_ack = 1'b1; slot_ecc_err = 2'b10; @(negedge clk);
        stop_ack = 1'b0; slot_ecc_err = '0;
        chk("R1", "error at ack keeps req", int'(stop_req), 1);
        chk("R2", "only new class kept", int'(req_cause), 2);
        ack();
        chk("R1", "req dropped", int'(stop_req), 0);
    endtask

    task automatic t_shared();
        wr(2'd0, EN | 6'd3);
        wr(2'd1, EN | 6'd7);
        wr(A_CTRL, 6'd0);
        msg(1'b0, 3, 0, 0);
        stop_out("R4", 3, 3, 1);
        msg(1'b0, 7, 0, 0);
        stop_out("R9", 3, 3, 1);
        repeat (2) @(negedge clk);
        stop_out("R9", 3, 3, 1);
        wr(A_CLR, 6'd0);
        stop_out("R10", 0, 0, 0);
        msg(1'b0, 7, 0, 0);
        stop_out("R8", 0, 0, 0);
        msg(1'b0, 3, 0, 0);
        stop_out("R8", 3, 3, 1);
        wr(A_CLR, 6'd0);
    endtask

    task automatic t_split();
        wr(A_CTRL, EN | 6'd9);
        msg(1'b0, 7, 0, 0);
        stop_out("R5", 2, 2, 1);
        wr(A_CLR, 6'd0);
        msg(1'b0, 3, 0, 0);
        stop_out("R5", 1, 1, 1);
        wr(A_CLR, 6'd0);
    endtask

    task automatic t_disabled();
        wr(2'd1, 6'd7);
        wr(A_CTRL, 6'd9);
        msg(1'b0, 3, 0, 0);
        stop_out("R6", 1, 3, 1);
        wr(A_CLR, 6'd0);
        wr(A_CTRL, EN | 6'd9);
        msg(1'b0, 7, 0, 0);
        stop_out("R6", 0, 2, 1);
        wr(A_CLR, 6'd0);
        wr(2'd1, EN | 6'd7);
    endtask

    task automatic t_port();
        msg(1'b1, 0, 9, 1);
        stop_out("R7", 2, 2, 1);
        wr(A_CLR, 6'd0);
        msg(1'b1, 0, 4, 1);
        stop_out("R7", 0, 0, 0);
        wr(A_CTRL, 6'd9);
        msg(1'b1, 0, 9, 0);
        stop_out("R7", 3, 3, 1);
        wr(A_CLR, 6'd0);
    endtask

    task automatic t_clear_race();
        msg_valid = 1'b1; msg_kind = 1'b0; msg_dom = 5'd3;
        cfg_we = 1'b1; cfg_addr = A_CLR; cfg_wdata = '0;
        @(negedge clk);
        msg_valid = 1'b0; cfg_we = 1'b0;
        stop_out("R10", 0, 0, 0);
        msg(1'b0, 3, 0, 0);
        stop_out("R3", 3, 3, 1);
        wr(A_CLR, 6'd0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_upward();
        t_shared();
        t_split();
        t_disabled();
        t_port();
        t_clear_race();
        finish_run();
    end
endmodule